// File: doc/BRIEF.md
# Sign-Magnitude Adder

This block adds two numbers held in sign-magnitude form. Each operand is a sign bit, with 1 meaning negative, and an unsigned magnitude that is `WIDTH` bits wide. When the two signs agree, the magnitudes are summed and the common sign is kept. When the signs disagree, the block returns the absolute difference of the magnitudes. The result takes the sign of whichever operand has the larger magnitude.

All three cases go through one logarithmic-depth parallel-prefix carry tree. On the difference path the second magnitude is complemented before it enters the tree. The carry-out state of the tree (kill, propagate or generate) then decides how a final correction row treats the per-bit carries. That row has three settings: pass the carries through (sum), add one (first minus second), or complement the result (second minus first). There is no clock and no storage.

The ports are plain combinational pins with no valid/ready handshake. A result is present whenever the operands are stable, so back-pressure does not arise. A caller that needs a stream wraps the block in its own pipeline register.

Top module: `signmag_adder`

## Requirements
- R1: When `sgn_a == sgn_b` and `mag_a + mag_b < 2^WIDTH`, `mag_s` equals `mag_a + mag_b`, `sgn_s` equals `sgn_a`, and `ovf` is 0.
- R2: When the signs differ and `mag_a > mag_b`, `mag_s` equals `mag_a - mag_b` and `sgn_s` equals `sgn_a`.
- R3: When the signs differ and `mag_a < mag_b`, `mag_s` equals `mag_b - mag_a` and `sgn_s` equals `sgn_b`.
- R4: When the signs differ and the magnitudes are equal, `mag_s` is 0 and `sgn_s` equals `sgn_a`. The output never drops to a zero that carries the other operand's sign.
- R5: When the signs agree and `mag_a + mag_b >= 2^WIDTH`, `ovf` is 1, `mag_s` equals `(mag_a + mag_b) mod 2^WIDTH`, and `sgn_s` equals `sgn_a`.
- R6: `ovf` is 0 whenever the signs differ.
- R7: The outputs are a pure function of the current inputs. They are valid in the same cycle the operands change, and no earlier operand affects them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sgn_a | input | 1 | Sign of operand A (1 = negative) |
| mag_a | input | WIDTH | Magnitude of operand A |
| sgn_b | input | 1 | Sign of operand B (1 = negative) |
| mag_b | input | WIDTH | Magnitude of operand B |
| sgn_s | output | 1 | Sign of the result |
| mag_s | output | WIDTH | Magnitude of the result |
| ovf | output | 1 | Same-sign sum exceeded the magnitude range |

## Verification
On a same-sign addition that carries out of the top bit, two things happen together: the overflow flag rises and the magnitude wraps modulo 2^WIDTH. Both come from the same generate state at the top of the prefix tree. The overflow scenario drives every same-sign pair whose sum reaches 2^WIDTH, at widths 4 and 5, and checks the flag and the wrapped magnitude against each other in that one sample. Separate scenarios confirm that the flag stays low for every differing-sign pair, including the equal-magnitude case. In that case the propagate state selects increment instead of invert.

// File: rtl/smadd_pkg.sv
package smadd_pkg;

  // Carry state of a bit group.
  typedef enum logic [1:0] {
    CS_KILL = 2'd0,
    CS_PROP = 2'd1,
    CS_GEN  = 2'd2
  } carry_state_e;

  // Mode of the correction row.
  typedef enum logic [1:0] {
    FIX_PASS = 2'd0,
    FIX_INC  = 2'd1,
    FIX_INV  = 2'd2
  } fix_mode_e;

  function automatic carry_state_e state_of(input logic g, input logic p);
    if (g)      return CS_GEN;
    else if (p) return CS_PROP;
    else        return CS_KILL;
  endfunction

  // Turns a carry state into a carry bit under a correction mode.
  function automatic logic carry_of(input carry_state_e st, input fix_mode_e md);
    case (md)
      FIX_INC: return (st != CS_KILL);
      FIX_INV: return (st != CS_GEN);
      default: return (st == CS_GEN);
    endcase
  endfunction

endpackage

// File: rtl/smadd_pg_leaf.sv
module smadd_pg_leaf #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             flip_b,
  output logic [WIDTH-1:0] bit_g,
  output logic [WIDTH-1:0] bit_p
);
  logic [WIDTH-1:0] opb_eff;

  assign opb_eff = flip_b ? ~opb : opb;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_g[i] = opa[i] & opb_eff[i];
    assign bit_p[i] = opa[i] ^ opb_eff[i];
  end
endmodule

// File: rtl/smadd_sklansky.sv
module smadd_sklansky #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bit_g,
  input  logic [WIDTH-1:0] bit_p,
  output logic [WIDTH-1:0] grp_g,   // generate of bits [i:0]
  output logic [WIDTH-1:0] grp_p    // propagate of bits [i:0]
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [LEVELS:0][WIDTH-1:0] lvl_g;
  logic [LEVELS:0][WIDTH-1:0] lvl_p;

  assign lvl_g[0] = bit_g;
  assign lvl_p[0] = bit_p;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    for (genvar i = 0; i < WIDTH; i++) begin : g_node
      localparam int SRC = ((i >> k) << k) - 1;
      if (((i >> k) & 1) == 1) begin : g_merge
        assign lvl_g[k+1][i] = lvl_g[k][i] | (lvl_p[k][i] & lvl_g[k][SRC]);
        assign lvl_p[k+1][i] = lvl_p[k][i] & lvl_p[k][SRC];
      end else begin : g_pass
        assign lvl_g[k+1][i] = lvl_g[k][i];
        assign lvl_p[k+1][i] = lvl_p[k][i];
      end
    end
  end

  assign grp_g = lvl_g[LEVELS];
  assign grp_p = lvl_p[LEVELS];
endmodule

// File: rtl/smadd_fix_row.sv
module smadd_fix_row
  import smadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bit_p,
  input  logic [WIDTH-1:0] grp_g,
  input  logic [WIDTH-1:0] grp_p,
  input  fix_mode_e        mode,
  output logic [WIDTH-1:0] sum
);
  // Bit 0 sees the empty group below it, which counts as propagate,
  // so the mode alone sets its carry-in.
  assign sum[0] = bit_p[0] ^ carry_of(CS_PROP, mode);

  for (genvar i = 1; i < WIDTH; i++) begin : g_col
    carry_state_e below;
    assign below  = state_of(grp_g[i-1], grp_p[i-1]);
    assign sum[i] = bit_p[i] ^ carry_of(below, mode);
  end
endmodule

// File: rtl/signmag_adder.sv
module signmag_adder
  import smadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             sgn_a,
  input  logic [WIDTH-1:0] mag_a,
  input  logic             sgn_b,
  input  logic [WIDTH-1:0] mag_b,
  output logic             sgn_s,
  output logic [WIDTH-1:0] mag_s,
  output logic             ovf
);
  logic             sub_path;
  logic [WIDTH-1:0] bit_g, bit_p, grp_g, grp_p;
  carry_state_e     top_state;
  logic             feedback;
  fix_mode_e        mode;

  assign sub_path = sgn_a ^ sgn_b;

  smadd_pg_leaf #(.WIDTH(WIDTH)) u_leaf (
    .opa(mag_a), .opb(mag_b), .flip_b(sub_path),
    .bit_g(bit_g), .bit_p(bit_p)
  );

  smadd_sklansky #(.WIDTH(WIDTH)) u_tree (
    .bit_g(bit_g), .bit_p(bit_p), .grp_g(grp_g), .grp_p(grp_p)
  );

  assign top_state = state_of(grp_g[WIDTH-1], grp_p[WIDTH-1]);
  // Kill folds to 0; propagate and generate fold to 1.
  assign feedback  = (top_state != CS_KILL);

  always_comb begin
    if (!sub_path)     mode = FIX_PASS;
    else if (feedback) mode = FIX_INC;
    else               mode = FIX_INV;
  end

  smadd_fix_row #(.WIDTH(WIDTH)) u_fix (
    .bit_p(bit_p), .grp_g(grp_g), .grp_p(grp_p), .mode(mode), .sum(mag_s)
  );

  assign sgn_s = (sub_path && !feedback) ? sgn_b : sgn_a;
  assign ovf   = !sub_path && (top_state == CS_GEN);

  // Checks of the result against arithmetic on the operands.
  always_comb begin
    if (!$isunknown({sgn_a, sgn_b, mag_a, mag_b})) begin
      if (!sub_path) begin
        a_r1_same_sign_sum: assert ({ovf, mag_s} == ({1'b0, mag_a} + {1'b0, mag_b}) && sgn_s == sgn_a)
          else $error("same-sign sum wrong");
      end
      if (sub_path && mag_a > mag_b) begin
        a_r2_a_larger: assert (mag_s == mag_a - mag_b && sgn_s == sgn_a)
          else $error("A-B path wrong");
      end
      if (sub_path && mag_a < mag_b) begin
        a_r3_b_larger: assert (mag_s == mag_b - mag_a && sgn_s == sgn_b)
          else $error("B-A path wrong");
      end
      if (sub_path && mag_a == mag_b) begin
        a_r4_equal_zero: assert (mag_s == '0 && sgn_s == sgn_a)
          else $error("equal-magnitude cancel wrong");
      end
      if (sub_path) begin
        a_r6_no_overflow: assert (!ovf) else $error("overflow on difference");
      end
    end
  end
endmodule

// File: tb/test_signmag_adder.sv
module test_signmag_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic       sa4, sb4, ss4, ov4;
  logic [3:0] ma4, mb4, ms4;
  logic       sa5, sb5, ss5, ov5;
  logic [4:0] ma5, mb5, ms5;

  signmag_adder #(.WIDTH(4)) i_signmag_adder (
    .sgn_a(sa4), .mag_a(ma4), .sgn_b(sb4), .mag_b(mb4),
    .sgn_s(ss4), .mag_s(ms4), .ovf(ov4)
  );

  signmag_adder #(.WIDTH(5)) i_signmag_adder_w5 (
    .sgn_a(sa5), .mag_a(ma5), .sgn_b(sb5), .mag_b(mb5),
    .sgn_s(ss5), .mag_s(ms5), .ovf(ov5)
  );

  // Drive one case at the chosen width, then compare with the arithmetic model.
  task automatic run_case(input int w, input bit sa, input int ma,
                          input bit sb, input int mb, input string tag);
    int lim, e_mag, e_sgn, e_ovf, a_mag, a_sgn, a_ovf;
    lim = 1 << w;
    if (sa == sb) begin
      e_mag = (ma + mb) % lim; e_sgn = sa; e_ovf = (ma + mb >= lim);
    end else if (ma >= mb) begin
      e_mag = ma - mb; e_sgn = sa; e_ovf = 0;
    end else begin
      e_mag = mb - ma; e_sgn = sb; e_ovf = 0;
    end
    @(negedge clk);
    if (w == 4) begin
      sa4 = sa; ma4 = 4'(ma); sb4 = sb; mb4 = 4'(mb);
    end else begin
      sa5 = sa; ma5 = 5'(ma); sb5 = sb; mb5 = 5'(mb);
    end
    #1;
    if (w == 4) begin a_mag = ms4; a_sgn = ss4; a_ovf = ov4; end
    else        begin a_mag = ms5; a_sgn = ss5; a_ovf = ov5; end
    n_checks++;
    if (a_mag != e_mag || a_sgn != e_sgn || a_ovf != e_ovf) begin
      n_fail++;
      $display("FAIL %s w=%0d a=%0d:%0d b=%0d:%0d actual s=%0d m=%0d o=%0d expected s=%0d m=%0d o=%0d",
               tag, w, sa, ma, sb, mb, a_sgn, a_mag, a_ovf, e_sgn, e_mag, e_ovf);
    end
  endtask

  task automatic t_idle();  // R1 at the all-zero operand after reset
    run_case(4, 0, 0, 0, 0, "R1");
    run_case(5, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_same_sign();  // R1
    for (int w = 4; w <= 5; w++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < (1 << w); a++)
          for (int b = 0; b < (1 << w); b++)
            if (a + b < (1 << w)) run_case(w, s[0], a, s[0], b, "R1");
  endtask

  task automatic t_overflow();  // R5
    for (int w = 4; w <= 5; w++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < (1 << w); a++)
          for (int b = 0; b < (1 << w); b++)
            if (a + b >= (1 << w)) run_case(w, s[0], a, s[0], b, "R5");
  endtask

  task automatic t_a_larger();  // R2, R6
    for (int w = 4; w <= 5; w++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < (1 << w); a++)
          for (int b = 0; b < a; b++)
            run_case(w, s[0], a, !s[0], b, "R2/R6");
  endtask

  task automatic t_b_larger();  // R3, R6
    for (int w = 4; w <= 5; w++)
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < (1 << w); b++)
          for (int a = 0; a < b; a++)
            run_case(w, s[0], a, !s[0], b, "R3/R6");
  endtask

  task automatic t_equal_mag();  // R4
    for (int w = 4; w <= 5; w++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < (1 << w); a++)
          run_case(w, s[0], a, !s[0], a, "R4");
  endtask

  task automatic t_back_to_back();  // R7: extreme operands in successive cycles
    run_case(4, 0, 15, 0, 15, "R7");
    run_case(4, 1, 0, 0, 15, "R7");
    run_case(4, 0, 15, 1, 0, "R7");
    run_case(5, 1, 31, 1, 1, "R7");
    run_case(5, 0, 1, 1, 31, "R7");
    run_case(5, 1, 16, 0, 16, "R7");
  endtask

  initial begin
    {sa4, sb4, ma4, mb4} = '0;
    {sa5, sb5, ma5, mb5} = '0;
    repeat (3) @(posedge clk);
    t_idle();
    t_same_sign();
    t_overflow();
    t_a_larger();
    t_b_larger();
    t_equal_mag();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule